// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash and drives the chip-enable, output-enable and write-enable strobes itself. A client hands it one request at a time: program a run of consecutive bytes starting at an address, erase one 4 KB page, or erase the whole device. For each request the block issues the unlock-and-command write series the flash expects. It then reads the device repeatedly until the flash reports that its internal operation has finished.

Completion is detected in one of two selectable ways. Data polling compares status bit 7 against the value expected once the operation is over. Toggle detection watches whether status bit 6 still flips between back-to-back reads. A poll budget bounds the wait, and the block ends each request with either a done pulse or a timeout pulse. Strobe low time, recovery time and read sampling delay are all counted in clock cycles, so one netlist can be fitted to different flash speed grades.

Program data is pulled one byte at a time from a simple source. The block captures `byte_in` when it starts a byte and pulses `byte_take`. The source must then present the next byte before the following capture.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program request issues, per byte, four writes in this order: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0, then the target address with the byte captured from `byte_in`.
- R2: A program request with `req_len` = N writes N+1 bytes to consecutive addresses starting at `req_addr`. Each byte waits for completion before the next byte's command series begins. `byte_take` pulses once per byte, and `done` pulses once after the last byte.
- R3: A page erase (`req_op` = 2'b01) issues 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then the page base address (`req_addr` with its low 12 bits cleared) with 0x50.
- R4: A chip erase (`req_op` = 2'b10) issues the same first five writes as R3, followed by 0x5555/0x10.
- R5: With `req_toggle_mode` = 0, each read is one poll step, and the byte or erase is complete once status bit 7 equals the expected value. That value is bit 7 of the programmed byte for a program, and 1 for either erase. Reads go to the byte being programmed, the page base, or address 0 for a chip erase.
- R6: With `req_toggle_mode` = 1, each read after the first of a byte or erase is compared with the read before it. The operation is complete once status bit 6 is equal in the two reads.
- R7: A write drives `fl_we_n` low with `fl_ce_n` low, `fl_oe_n` high and `fl_dq_oe` high. A read drives `fl_ce_n` and `fl_oe_n` low with `fl_we_n` high and `fl_dq_oe` low. `fl_we_n` and `fl_oe_n` are never low together.
- R8: Each write holds `fl_we_n` low for exactly T_WP cycles. Each read holds `fl_oe_n` low for exactly T_RD cycles and samples at the end of that window. `fl_ce_n` stays high for at least T_WH cycles between accesses.
- R9: If POLL_LIMIT consecutive poll comparisons all fail, `timeout` pulses for one cycle, `done` does not pulse, and the block returns to idle.
- R10: `busy` is high from the cycle after a request is accepted until the cycle in which `done` or `timeout` pulses. Requests presented while busy are ignored, and `req_op` = 2'b11 is ignored.
- R11: After reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, `fl_dq_oe`, `busy`, `done`, `timeout` and `byte_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 00 program, 01 page erase, 10 chip erase, 11 none |
| req_addr | input | AW | Start address (program) or any address in the page |
| req_len | input | LW | Number of bytes to program minus one |
| req_toggle_mode | input | 1 | 0 data polling on bit 7, 1 toggle detection on bit 6 |
| byte_in | input | 8 | Next program byte |
| byte_take | output | 1 | One-cycle pulse after `byte_in` was captured |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse when the poll budget ran out |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Flash data bus drive enable |
| fl_dq_hi | input | 2 | Flash status bits DQ7 (bit 1) and DQ6 (bit 0) |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The bench builds the block with T_WP = 3, T_RD = 2 and T_WH = 2. Because the write and read windows differ, a swapped or off-by-one strobe counter shows up in the measured pulse widths. POLL_LIMIT is reduced to 8, so timeouts in both completion modes are reached in a few hundred cycles, and the exact read count at timeout separates the data-polling budget from the toggle budget, which needs one extra read. The bench also includes a multi-byte program that crosses a page boundary and a program at the top address.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_PERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_NONE   = 2'd3
  } fop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WRW,
    ST_RD,
    ST_RDW
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACT,
    PH_REC
  } phy_st_e;
endpackage

// File: rtl/flash_bus_phy.sv
module flash_bus_phy
  import flash_seq_pkg::*;
#(
  parameter int AW   = 17,
  parameter int T_WP = 4,
  parameter int T_WH = 2,
  parameter int T_RD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          done,
  output logic [1:0]    rstat,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [1:0]    fl_dq_hi,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int CMAX1 = (T_WP > T_RD) ? T_WP : T_RD;
  localparam int CMAX  = (CMAX1 > T_WH) ? CMAX1 : T_WH;
  localparam int CW    = $clog2(CMAX + 1);

  phy_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, done_q, done_d, load, cap;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [1:0]    rstat_q;
  logic [CW-1:0] act_last;

  assign act_last = wr_q ? CW'(T_WP - 1) : CW'(T_RD - 1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    load   = 1'b0;
    cap    = 1'b0;
    case (st_q)
      PH_IDLE: if (start) begin
        load  = 1'b1;
        st_d  = PH_ACT;
        cnt_d = '0;
      end
      PH_ACT: if (cnt_q == act_last) begin
        st_d  = PH_REC;
        cnt_d = '0;
        cap   = !wr_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      PH_REC: if (cnt_q == CW'(T_WH - 1)) begin
        st_d   = PH_IDLE;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rstat_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (load) begin
        wr_q   <= is_wr;
        addr_q <= addr;
        data_q <= wdata;
      end
      if (cap) rstat_q <= fl_dq_hi;
    end
  end

  assign fl_ce_n   = (st_q != PH_ACT);
  assign fl_we_n   = !((st_q == PH_ACT) && wr_q);
  assign fl_oe_n   = !((st_q == PH_ACT) && !wr_q);
  assign fl_dq_oe  = (st_q == PH_ACT) && wr_q;
  assign fl_addr   = addr_q;
  assign fl_dq_out = data_q;
  assign done      = done_q;
  assign rstat     = rstat_q;
endmodule

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_seq_pkg::*;
#(
  parameter int AW        = 17,
  parameter int PAGE_BITS = 12
) (
  input  fop_e          op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          last
);
  localparam logic [AW-1:0] UNLK_A = AW'('h5555);
  localparam logic [AW-1:0] UNLK_B = AW'('h2AAA);

  logic [AW-1:0] page_base;
  assign page_base = {tgt_addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};

  always_comb begin
    wr_addr = UNLK_A;
    wr_data = 8'hAA;
    last    = 1'b0;
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin wr_addr = UNLK_A; wr_data = 8'hAA; end
        3'd1: begin wr_addr = UNLK_B; wr_data = 8'h55; end
        3'd2: begin wr_addr = UNLK_A; wr_data = 8'hA0; end
        default: begin wr_addr = tgt_addr; wr_data = tgt_data; last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0: begin wr_addr = UNLK_A; wr_data = 8'hAA; end
        3'd1: begin wr_addr = UNLK_B; wr_data = 8'h55; end
        3'd2: begin wr_addr = UNLK_A; wr_data = 8'h80; end
        3'd3: begin wr_addr = UNLK_A; wr_data = 8'hAA; end
        3'd4: begin wr_addr = UNLK_B; wr_data = 8'h55; end
        default: begin
          last = 1'b1;
          if (op == OP_PERASE) begin
            wr_addr = page_base;
            wr_data = 8'h50;
          end else begin
            wr_addr = UNLK_A;
            wr_data = 8'h10;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval (
  input  logic toggle_mode,
  input  logic exp7,
  input  logic cur7,
  input  logic cur6,
  input  logic prev6,
  input  logic have_prev,
  output logic evaluated,
  output logic finished
);
  always_comb begin
    if (toggle_mode) begin
      evaluated = have_prev;
      finished  = (cur6 == prev6);
    end else begin
      evaluated = 1'b1;
      finished  = (cur7 == exp7);
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW         = 17,
  parameter int LW         = 8,
  parameter int PAGE_BITS  = 12,
  parameter int T_WP       = 4,
  parameter int T_WH       = 2,
  parameter int T_RD       = 3,
  parameter int POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_toggle_mode,
  input  logic [7:0]    byte_in,
  output logic          byte_take,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [1:0]    fl_dq_hi,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);

  seq_st_e        st_q, st_d;
  fop_e           op_q, op_d;
  logic           tog_q, tog_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [LW-1:0]  rem_q, rem_d;
  logic [7:0]     byte_q, byte_d;
  logic [2:0]     step_q, step_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           prev6_q, prev6_d, havep_q, havep_d;
  logic           take_d, take_q, done_d, done_q, to_d, to_q;

  logic           phy_start, phy_wr, phy_done;
  logic [AW-1:0]  phy_addr, rom_addr, poll_addr;
  logic [7:0]     phy_data, rom_data;
  logic [1:0]     phy_stat;
  logic           rom_last, exp7, ev_valid, ev_fin;

  flash_cmd_rom #(.AW(AW), .PAGE_BITS(PAGE_BITS)) rom_i (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(byte_q),
    .wr_addr(rom_addr), .wr_data(rom_data), .last(rom_last)
  );

  flash_poll_eval eval_i (
    .toggle_mode(tog_q), .exp7(exp7), .cur7(phy_stat[1]), .cur6(phy_stat[0]),
    .prev6(prev6_q), .have_prev(havep_q), .evaluated(ev_valid), .finished(ev_fin)
  );

  flash_bus_phy #(.AW(AW), .T_WP(T_WP), .T_WH(T_WH), .T_RD(T_RD)) phy_i (
    .clk(clk), .rst_n(rst_n), .start(phy_start), .is_wr(phy_wr),
    .addr(phy_addr), .wdata(phy_data), .done(phy_done), .rstat(phy_stat),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_hi(fl_dq_hi), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  always_comb begin
    case (op_q)
      OP_PROG:   poll_addr = addr_q;
      OP_PERASE: poll_addr = {addr_q[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      default:   poll_addr = '0;
    endcase
  end
  assign exp7 = (op_q == OP_PROG) ? byte_q[7] : 1'b1;

  always_comb begin
    st_d = st_q; op_d = op_q; tog_d = tog_q; addr_d = addr_q; rem_d = rem_q;
    byte_d = byte_q; step_d = step_q; pcnt_d = pcnt_q;
    prev6_d = prev6_q; havep_d = havep_q;
    take_d = 1'b0; done_d = 1'b0; to_d = 1'b0;
    phy_start = 1'b0; phy_wr = 1'b0; phy_addr = rom_addr; phy_data = rom_data;
    case (st_q)
      ST_IDLE: if (req_valid && (fop_e'(req_op) != OP_NONE)) begin
        op_d   = fop_e'(req_op);
        tog_d  = req_toggle_mode;
        addr_d = req_addr;
        rem_d  = req_len;
        step_d = '0;
        st_d   = ST_WR;
        if (fop_e'(req_op) == OP_PROG) begin
          byte_d = byte_in;
          take_d = 1'b1;
        end
      end
      ST_WR: begin
        phy_start = 1'b1;
        phy_wr    = 1'b1;
        st_d      = ST_WRW;
      end
      ST_WRW: if (phy_done) begin
        if (rom_last) begin
          st_d    = ST_RD;
          pcnt_d  = '0;
          havep_d = 1'b0;
        end else begin
          step_d = step_q + 3'd1;
          st_d   = ST_WR;
        end
      end
      ST_RD: begin
        phy_start = 1'b1;
        phy_addr  = poll_addr;
        st_d      = ST_RDW;
      end
      ST_RDW: if (phy_done) begin
        prev6_d = phy_stat[0];
        havep_d = 1'b1;
        if (ev_valid && ev_fin) begin
          if ((op_q == OP_PROG) && (rem_q != '0)) begin
            addr_d = addr_q + AW'(1);
            rem_d  = rem_q - LW'(1);
            byte_d = byte_in;
            take_d = 1'b1;
            step_d = '0;
            st_d   = ST_WR;
          end else begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end else if (ev_valid && (pcnt_q == PCW'(POLL_LIMIT - 1))) begin
          to_d = 1'b1;
          st_d = ST_IDLE;
        end else begin
          if (ev_valid) pcnt_d = pcnt_q + PCW'(1);
          st_d = ST_RD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; op_q <= OP_NONE; tog_q <= 1'b0; addr_q <= '0;
      rem_q <= '0; byte_q <= '0; step_q <= '0; pcnt_q <= '0;
      prev6_q <= 1'b0; havep_q <= 1'b0;
      take_q <= 1'b0; done_q <= 1'b0; to_q <= 1'b0;
    end else begin
      st_q <= st_d; op_q <= op_d; tog_q <= tog_d; addr_q <= addr_d;
      rem_q <= rem_d; byte_q <= byte_d; step_q <= step_d; pcnt_q <= pcnt_d;
      prev6_q <= prev6_d; havep_q <= havep_d;
      take_q <= take_d; done_q <= done_d; to_q <= to_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign byte_take = take_q;
  assign done      = done_q;
  assign timeout   = to_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic byte_take,
  input logic fl_ce_n,
  input logic fl_oe_n,
  input logic fl_we_n,
  input logic fl_dq_oe
);
  assert_strobe_in_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

  assert_no_we_oe_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  assert_drive_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_dq_oe |-> (fl_oe_n && !fl_we_n));

  assert_end_drops_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> ($past(busy) && !busy));

  assert_done_excl_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  assert_take_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> busy);

  assert_idle_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ce_n && !fl_dq_oe));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout(timeout),
  .byte_take(byte_take), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
  .fl_we_n(fl_we_n), .fl_dq_oe(fl_dq_oe)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int AW = 17, LW = 8, PB = 12;
  localparam int TWP = 3, TWH = 2, TRD = 2, PL = 8;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
    logic          mode;
    logic [3:0]    br;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{2'd0, 17'h01234, 8'd0, 1'b0, 4'd3},
    '{2'd0, 17'h00FFE, 8'd3, 1'b1, 4'd2},
    '{2'd1, 17'h15A7C, 8'd0, 1'b0, 4'd5},
    '{2'd2, 17'h0ABCD, 8'd0, 1'b0, 4'd4},
    '{2'd1, 17'h0F123, 8'd0, 1'b1, 4'd3},
    '{2'd0, 17'h1FFFF, 8'd0, 1'b1, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic          req_valid, req_toggle_mode;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [7:0]    byte_in;
  logic          byte_take, busy, done, timeout;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out;
  logic          fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
  logic [1:0]    fl_dq_hi;

  flash_cmd_seq #(.AW(AW), .LW(LW), .PAGE_BITS(PB), .T_WP(TWP), .T_WH(TWH),
                  .T_RD(TRD), .POLL_LIMIT(PL)) dut_i (.*);

  // bench-controlled model knobs
  logic          clr_req, hang;
  int            busy_reads;
  logic [AW-1:0] erase_exp;
  logic [7:0]    seed;

  // flash model state (owned by the model process)
  logic [AW-1:0] log_a [0:63];
  logic [7:0]    log_d [0:63];
  int nlog, nreads, bad_raddr, bad_t, ndone, nto, ntake, sidx, pend;
  int we_run, oe_run, hi_run;
  logic we_prev, oe_prev, ce_prev, started, tog, exp7, saw80, erase_op;
  logic [7:0]    prev_d, ready_val;
  logic [AW-1:0] prev_a, last_prog;

  function automatic logic [7:0] src_byte(int i, logic [7:0] s);
    return 8'h5B ^ 8'(i * 29) ^ s;
  endfunction

  assign byte_in  = src_byte(sidx, seed);
  assign fl_dq_hi = (pend > 0) ? {~exp7, tog} : ready_val[7:6];

  always @(negedge clk) begin
    if (clr_req) begin
      nlog = 0; nreads = 0; bad_raddr = 0; bad_t = 0; ndone = 0; nto = 0;
      ntake = 0; sidx = 0; pend = 0; we_run = 0; oe_run = 0; hi_run = 0;
      started = 1'b0; tog = 1'b0; exp7 = 1'b1; saw80 = 1'b0; erase_op = 1'b0;
      prev_d = 8'h00; prev_a = '0; ready_val = 8'hFF; last_prog = '0;
    end else if (rst_n) begin
      if (done) ndone++;
      if (timeout) nto++;
      if (byte_take) begin ntake++; sidx++; end
      if (we_prev == 1'b0 && fl_we_n == 1'b1) begin
        if (nlog < 64) begin log_a[nlog] = fl_addr; log_d[nlog] = fl_dq_out; nlog++; end
        if (prev_a == AW'('h5555) && prev_d == 8'hA0) begin
          pend = busy_reads; exp7 = fl_dq_out[7]; ready_val = fl_dq_out;
          last_prog = fl_addr; erase_op = 1'b0;
        end else if (saw80 && prev_d == 8'h55 && (fl_dq_out == 8'h50 || fl_dq_out == 8'h10)) begin
          pend = busy_reads; exp7 = 1'b1; ready_val = 8'hFF; saw80 = 1'b0; erase_op = 1'b1;
        end
        if (fl_dq_out == 8'h80) saw80 = 1'b1;
        prev_d = fl_dq_out; prev_a = fl_addr;
      end
      if (oe_prev == 1'b1 && fl_oe_n == 1'b0) begin
        nreads++;
        if (fl_addr != (erase_op ? erase_exp : last_prog)) bad_raddr++;
      end
      if (oe_prev == 1'b0 && fl_oe_n == 1'b1) begin
        if (!hang && pend > 0) pend--;
        tog = ~tog;
      end
      if (fl_we_n == 1'b0) we_run++;
      else if (we_prev == 1'b0) begin if (we_run != TWP) bad_t++; we_run = 0; end
      if (fl_oe_n == 1'b0) oe_run++;
      else if (oe_prev == 1'b0) begin if (oe_run != TRD) bad_t++; oe_run = 0; end
      if (fl_ce_n == 1'b1) hi_run++;
      else begin
        if (ce_prev == 1'b1 && started && hi_run < TWH) bad_t++;
        hi_run = 0; started = 1'b1;
      end
      if (!fl_we_n && !fl_oe_n) bad_t++;
      if ((!fl_we_n || !fl_oe_n) && fl_ce_n) bad_t++;
      if (!fl_we_n && !fl_dq_oe) bad_t++;
      if (!fl_oe_n && fl_dq_oe) bad_t++;
    end
    we_prev = fl_we_n; oe_prev = fl_oe_n; ce_prev = fl_ce_n;
  end

  int ntests = 0, nfail = 0;
  logic [AW-1:0] exp_a [0:63];
  logic [7:0]    exp_d [0:63];
  int nexp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_model();
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
    exp_a[nexp] = a; exp_d[nexp] = d; nexp++;
  endtask

  task automatic wait_end(input string req);
    int guard = 0;
    while (ndone == 0 && nto == 0 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    chk(guard < 20000, req, "watchdog expired waiting for end", guard, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [LW-1:0] len, input logic mode);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = len; req_toggle_mode = mode;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int k);
    string rq;
    int n, lo, hi;
    rq = (v.op == 2'd0) ? "R1" : (v.op == 2'd1) ? "R3" : "R4";
    seed = 8'(k * 17 + 3);
    busy_reads = int'(v.br); hang = 1'b0;
    erase_exp = (v.op == 2'd1) ? {v.addr[AW-1:PB], {PB{1'b0}}} : '0;
    clear_model();
    nexp = 0;
    if (v.op == 2'd0) begin
      for (int b = 0; b <= int'(v.len); b++) begin
        push(AW'('h5555), 8'hAA); push(AW'('h2AAA), 8'h55); push(AW'('h5555), 8'hA0);
        push(v.addr + AW'(b), src_byte(b, seed));
      end
    end else begin
      push(AW'('h5555), 8'hAA); push(AW'('h2AAA), 8'h55); push(AW'('h5555), 8'h80);
      push(AW'('h5555), 8'hAA); push(AW'('h2AAA), 8'h55);
      if (v.op == 2'd1) push(erase_exp, 8'h50); else push(AW'('h5555), 8'h10);
    end
    issue(v.op, v.addr, v.len, v.mode);
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    wait_end(rq);
    chk(ndone == 1 && nto == 0, "R2", "single done, no timeout", ndone * 10 + nto, 10);
    chk(nlog == nexp, rq, "write count", nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++)
      chk(log_a[i] == exp_a[i] && log_d[i] == exp_d[i], rq, "write addr/data",
          {log_a[i], log_d[i]}, {exp_a[i], exp_d[i]});
    n = (v.op == 2'd0) ? int'(v.len) + 1 : 1;
    chk(ntake == ((v.op == 2'd0) ? n : 0), "R2", "byte_take count", ntake,
        (v.op == 2'd0) ? n : 0);
    lo = (int'(v.br) + 1) * n;
    hi = v.mode ? (int'(v.br) + 2) * n : lo;
    chk(nreads >= lo && nreads <= hi, v.mode ? "R6" : "R5", "poll read count", nreads, lo);
    chk(bad_raddr == 0, "R5", "poll read address", bad_raddr, 0);
    chk(bad_t == 0, "R8", "strobe timing/levels (R7)", bad_t, 0);
    chk(busy == 1'b0, "R10", "idle after done", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd3; req_addr = '0; req_len = '0;
    req_toggle_mode = 1'b0; clr_req = 1'b0; hang = 1'b0; busy_reads = 0;
    erase_exp = '0; seed = 8'h00;
    clear_model();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R11", "strobes high in reset",
        {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    chk(!busy && !done && !timeout && !fl_dq_oe && !byte_take, "R11", "outputs low in reset",
        {busy, done, timeout, fl_dq_oe, byte_take}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(fl_ce_n && !busy, "R11", "idle after release", {fl_ce_n, busy}, 2);

    for (int k = 0; k < 6; k++) run_vec(VECS[k], k);

    // R9 timeout in data polling mode: exactly PL reads
    hang = 1'b1; busy_reads = 1; seed = 8'h21; clear_model();
    issue(2'd0, 17'h00400, 8'd0, 1'b0);
    wait_end("R9");
    chk(nto == 1 && ndone == 0, "R9", "timeout pulse, no done (data)", nto * 10 + ndone, 10);
    chk(nreads == PL, "R9", "reads before timeout (data)", nreads, PL);
    chk(!busy, "R9", "idle after timeout", busy, 0);

    // R9 timeout in toggle mode: PL comparisons need PL+1 reads
    clear_model();
    issue(2'd2, 17'h00000, 8'd0, 1'b1);
    wait_end("R9");
    chk(nto == 1 && ndone == 0, "R9", "timeout pulse, no done (toggle)", nto * 10 + ndone, 10);
    chk(nreads == PL + 1, "R9", "reads before timeout (toggle)", nreads, PL + 1);
    hang = 1'b0;

    // R10 request while busy is ignored
    busy_reads = 6; erase_exp = 17'h03000; clear_model();
    issue(2'd1, 17'h03456, 8'd0, 1'b0);
    repeat (3) @(negedge clk);
    issue(2'd0, 17'h00010, 8'd2, 1'b0);
    wait_end("R10");
    repeat (40) @(negedge clk);
    chk(nlog == 6, "R10", "writes with request while busy", nlog, 6);
    chk(ndone == 1 && ntake == 0, "R10", "one done, no byte taken", ndone * 10 + ntake, 10);
    chk(log_d[5] == 8'h50 && log_a[5] == 17'h03000, "R3", "page erase last write",
        {log_a[5], log_d[5]}, {17'h03000, 8'h50});

    // R10 reserved op code 2'b11 ignored
    clear_model();
    issue(2'd3, 17'h00020, 8'd0, 1'b0);
    chk(busy == 1'b0, "R10", "busy after op 3", busy, 0);
    repeat (30) @(negedge clk);
    chk(nlog == 0 && ndone == 0 && nto == 0, "R10", "no activity after op 3",
        nlog + ndone + nto, 0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule